// File: doc/BRIEF.md
# Overlay Color-Key Pixel Selector

This block decides, pixel by pixel, whether an overlay plane shows through or whether the pixel beneath it takes its place. A stored key holds a lower bound, an upper bound and a per-channel enable. A pixel counts as a key match when each enabled channel lies inside its bound pair. The block has three keying states: keying off, source keying and destination keying. Source keying tests the overlay pixel. Destination keying tests the underlying pixel.

The configuration is loaded with a single-cycle write strobe. That write carries both bounds, the channel enables and two mode request bits. A write that asks for both modes at once is refused. So is a destination request on a build whose `ALLOW_DST` parameter is 0. A refused write leaves every stored value as it was and raises an error flag. Pixels arrive with a valid bit and leave one register stage later, with the valid bit delayed by the same stage.

The configuration controller is a three-state machine. The states are KEY_OFF, KEY_SRC and KEY_DST. An accepted write moves it to the requested state: destination if the destination bit is set, otherwise source if the source bit is set, otherwise off. The `goto_dst` transition is checked first, then `goto_src`, then `goto_off`. A refused write or no write leaves the state unchanged (`stay`).

Top module: `ckey_comparator`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_px` is 0 and `cfg_err` is 0. The controller is in KEY_OFF and all key values are zero.
- R2: In KEY_OFF, a valid overlay pixel appears unchanged on `out_px` one clock after it is presented, whatever the underlying pixel.
- R3: `out_valid` equals `ovl_valid` of the previous clock. `out_px` holds its value in any cycle that follows one with `ovl_valid` low.
- R4: Pixels are packed with red in bits 23:16, green in 15:8 and blue in 7:0. Channel-enable bit 2 is red, bit 1 is green and bit 0 is blue. A pixel matches when every enabled channel c satisfies `kmin[c] <= px[c] <= kmax[c]`, bounds included. A disabled channel always counts as matching.
- R5: In KEY_SRC, an overlay pixel that matches is replaced by the underlying pixel. A non-matching overlay pixel is output.
- R6: In KEY_DST, the overlay pixel is output only where the underlying pixel matches. Elsewhere the underlying pixel is output.
- R7: A write with both mode request bits set is refused. `cfg_err` reads 1 from the next clock. The mode, both bounds and the channel enables keep their previous values.
- R8: With `ALLOW_DST` = 0, a write that requests destination keying is refused in the same way as in R7, and the controller never enters KEY_DST.
- R9: An accepted write clears `cfg_err` on the next clock. The pixel presented in the clock after the write strobe is the first one keyed with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src_req | input | 1 | Request source keying |
| cfg_dst_req | input | 1 | Request destination keying |
| cfg_kmin | input | 24 | Lower key bound per channel |
| cfg_kmax | input | 24 | Upper key bound per channel |
| cfg_chan_en | input | 3 | Per-channel compare enable |
| ovl_valid | input | 1 | Overlay pixel valid |
| ovl_px | input | 24 | Overlay pixel |
| und_px | input | 24 | Underlying pixel at the same position |
| out_valid | output | 1 | Output pixel valid |
| out_px | output | 24 | Selected pixel |
| cfg_err | output | 1 | Last configuration write was refused |

## Verification
The bench aims at the bound edges: channel values equal to `kmin`, equal to `kmax`, and one step outside each. A comparator written with strict inequalities would flip the decision exactly at the bounds. Partial channel enables are exercised too. A design that tested a disabled channel would replace pixels that should stay.

Refused writes carry new bounds and enables that differ from the stored ones. A design that loaded the values before rejecting the mode would key the next pixels against the wrong range, even though it reports the error. A second instance built without destination support receives the same stream. If it accepted a destination request, it would swap overlay and underlying pixels that the reference keeps.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
    typedef enum logic [1:0] {
        KEY_OFF = 2'd0,
        KEY_SRC = 2'd1,
        KEY_DST = 2'd2
    } key_mode_e;
endpackage

// File: rtl/ckey_cfg.sv
module ckey_cfg
    import ckey_pkg::*;
#(
    parameter int PX_W      = 24,
    parameter int N_CH      = 3,
    parameter bit ALLOW_DST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              src_req,
    input  logic              dst_req,
    input  logic [PX_W-1:0]   wr_min,
    input  logic [PX_W-1:0]   wr_max,
    input  logic [N_CH-1:0]   wr_en,
    output key_mode_e         mode,
    output logic [PX_W-1:0]   kmin,
    output logic [PX_W-1:0]   kmax,
    output logic [N_CH-1:0]   chan_en,
    output logic              err
);
    key_mode_e state_q, state_d;
    logic      refuse, accept;

    // both modes together, or destination on a build without it
    assign refuse = wr && ((src_req && dst_req) || (dst_req && !ALLOW_DST));
    assign accept = wr && !refuse;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_OFF, KEY_SRC, KEY_DST: begin
                if (accept) begin
                    if (dst_req)      state_d = KEY_DST;   // goto_dst
                    else if (src_req) state_d = KEY_SRC;   // goto_src
                    else              state_d = KEY_OFF;   // goto_off
                end
            end
            default: state_d = KEY_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kmin    <= '0;
            kmax    <= '0;
            chan_en <= '0;
            err     <= 1'b0;
        end else if (wr) begin
            err <= refuse;
            if (accept) begin
                kmin    <= wr_min;
                kmax    <= wr_max;
                chan_en <= wr_en;
            end
        end
    end

    assign mode = state_q;

    p_refuse_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && src_req && dst_req) |=> (state_q == $past(state_q)) && err
            && (kmin == $past(kmin)) && (kmax == $past(kmax)));

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(src_req && dst_req) && !(dst_req && !ALLOW_DST)) |=> !err);

    generate
        if (!ALLOW_DST) begin : g_nodst
            p_never_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
                state_q != KEY_DST);
        end
    endgenerate
endmodule

// File: rtl/ckey_match.sv
module ckey_match #(
    parameter int CH_W = 8,
    parameter int N_CH = 3
) (
    input  logic [CH_W*N_CH-1:0] px,
    input  logic [CH_W*N_CH-1:0] kmin,
    input  logic [CH_W*N_CH-1:0] kmax,
    input  logic [N_CH-1:0]      chan_en,
    output logic                 hit
);
    logic [N_CH-1:0] in_rng;

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            logic [CH_W-1:0] v, lo, hi;
            assign v  = px[c*CH_W +: CH_W];
            assign lo = kmin[c*CH_W +: CH_W];
            assign hi = kmax[c*CH_W +: CH_W];
            assign in_rng[c] = !chan_en[c] || ((v >= lo) && (v <= hi));
        end
    endgenerate

    assign hit = &in_rng;

    always_comb begin
        if (chan_en == '0) begin
            p_mask_off_match_r4: assert (hit);
        end
    end
endmodule

// File: rtl/ckey_comparator.sv
module ckey_comparator
    import ckey_pkg::*;
#(
    parameter int CH_W      = 8,
    parameter int N_CH      = 3,
    parameter bit ALLOW_DST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_src_req,
    input  logic                 cfg_dst_req,
    input  logic [CH_W*N_CH-1:0] cfg_kmin,
    input  logic [CH_W*N_CH-1:0] cfg_kmax,
    input  logic [N_CH-1:0]      cfg_chan_en,
    input  logic                 ovl_valid,
    input  logic [CH_W*N_CH-1:0] ovl_px,
    input  logic [CH_W*N_CH-1:0] und_px,
    output logic                 out_valid,
    output logic [CH_W*N_CH-1:0] out_px,
    output logic                 cfg_err
);
    localparam int PX_W = CH_W * N_CH;

    key_mode_e       mode;
    logic [PX_W-1:0] kmin, kmax, probe_px, pick_px;
    logic [N_CH-1:0] chan_en;
    logic            hit;

    ckey_cfg #(.PX_W(PX_W), .N_CH(N_CH), .ALLOW_DST(ALLOW_DST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_we),
        .src_req(cfg_src_req), .dst_req(cfg_dst_req),
        .wr_min(cfg_kmin), .wr_max(cfg_kmax), .wr_en(cfg_chan_en),
        .mode(mode), .kmin(kmin), .kmax(kmax), .chan_en(chan_en), .err(cfg_err)
    );

    assign probe_px = (mode == KEY_DST) ? und_px : ovl_px;

    ckey_match #(.CH_W(CH_W), .N_CH(N_CH)) u_match (
        .px(probe_px), .kmin(kmin), .kmax(kmax), .chan_en(chan_en), .hit(hit)
    );

    always_comb begin
        unique case (mode)
            KEY_SRC: pick_px = hit ? und_px : ovl_px;
            KEY_DST: pick_px = hit ? ovl_px : und_px;
            default: pick_px = ovl_px;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_px    <= '0;
        end else begin
            out_valid <= ovl_valid;
            if (ovl_valid) out_px <= pick_px;
        end
    end

    p_valid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_valid |=> out_valid);
    p_valid_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_valid |=> !out_valid && $stable(out_px));
    p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_valid && mode == KEY_OFF) |=> out_px == $past(ovl_px));
endmodule

// File: tb/ckey_comparator_tb.sv
module ckey_comparator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_src_req = 1'b0, cfg_dst_req = 1'b0;
    logic [23:0] cfg_kmin = '0, cfg_kmax = '0;
    logic [2:0]  cfg_chan_en = '0;
    logic        ovl_valid = 1'b0;
    logic [23:0] ovl_px = '0, und_px = '0;
    logic        out_valid, cfg_err, nd_valid, nd_err;
    logic [23:0] out_px, nd_px;

    int total = 0, bad = 0;
    string req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    ckey_comparator u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src_req(cfg_src_req),
        .cfg_dst_req(cfg_dst_req), .cfg_kmin(cfg_kmin), .cfg_kmax(cfg_kmax),
        .cfg_chan_en(cfg_chan_en), .ovl_valid(ovl_valid), .ovl_px(ovl_px),
        .und_px(und_px), .out_valid(out_valid), .out_px(out_px), .cfg_err(cfg_err)
    );

    ckey_comparator #(.ALLOW_DST(1'b0)) u_nodst (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src_req(cfg_src_req),
        .cfg_dst_req(cfg_dst_req), .cfg_kmin(cfg_kmin), .cfg_kmax(cfg_kmax),
        .cfg_chan_en(cfg_chan_en), .ovl_valid(ovl_valid), .ovl_px(ovl_px),
        .und_px(und_px), .out_valid(nd_valid), .out_px(nd_px), .cfg_err(nd_err)
    );

    // behavioural reference: index 0 = full build, 1 = no destination keying
    int          m_mode [2];   // 0 off, 1 source, 2 destination
    logic [23:0] m_min [2], m_max [2], e_px [2];
    logic [2:0]  m_en [2];
    logic        m_err [2];
    logic        e_valid;

    function automatic bit in_key(logic [23:0] px, logic [23:0] lo, logic [23:0] hi, logic [2:0] en);
        for (int c = 0; c < 3; c++) begin
            int v, a, b;
            v = px[c*8 +: 8]; a = lo[c*8 +: 8]; b = hi[c*8 +: 8];
            if (en[c] && (v < a || v > b)) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_mode[k] = 0; m_min[k] = 0; m_max[k] = 0; m_en[k] = 0;
                m_err[k] = 0; e_px[k] = 0;
            end
            e_valid = 0;
        end else begin
            e_valid = ovl_valid;
            for (int k = 0; k < 2; k++) begin
                if (ovl_valid) begin
                    if (m_mode[k] == 1)
                        e_px[k] = in_key(ovl_px, m_min[k], m_max[k], m_en[k]) ? und_px : ovl_px;
                    else if (m_mode[k] == 2)
                        e_px[k] = in_key(und_px, m_min[k], m_max[k], m_en[k]) ? ovl_px : und_px;
                    else
                        e_px[k] = ovl_px;
                end
                if (cfg_we) begin
                    if ((cfg_src_req && cfg_dst_req) || (cfg_dst_req && k == 1)) begin
                        m_err[k] = 1;
                    end else begin
                        m_err[k] = 0;
                        m_min[k] = cfg_kmin; m_max[k] = cfg_kmax; m_en[k] = cfg_chan_en;
                        m_mode[k] = cfg_dst_req ? 2 : (cfg_src_req ? 1 : 0);
                    end
                end
            end
        end
    end

    task automatic check(string tag, string what, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", "out_valid", {23'd0, out_valid}, {23'd0, e_valid});
            check(req, "out_px", out_px, e_px[0]);
            check("R9", "cfg_err", {23'd0, cfg_err}, {23'd0, m_err[0]});
            check("R8", "nodst out_px", nd_px, e_px[1]);
            check("R8", "nodst cfg_err", {23'd0, nd_err}, {23'd0, m_err[1]});
        end
    end

    task automatic pix(bit v, logic [23:0] o, logic [23:0] u);
        @(negedge clk);
        cfg_we = 0; cfg_src_req = 0; cfg_dst_req = 0;
        ovl_valid = v; ovl_px = o; und_px = u;
    endtask

    task automatic wr(bit s, bit d, logic [23:0] lo, logic [23:0] hi, logic [2:0] en);
        @(negedge clk);
        cfg_we = 1; cfg_src_req = s; cfg_dst_req = d;
        cfg_kmin = lo; cfg_kmax = hi; cfg_chan_en = en;
        ovl_valid = 0;
    endtask

    task automatic rnd_px(int n);
        for (int i = 0; i < n; i++)
            pix($urandom_range(0, 3) != 0, 24'($urandom), 24'($urandom));
    endtask

    // channel values at and just past the bounds 10..40 / 20..50 / 30..60
    task automatic edge_px(bit dst_side);
        logic [23:0] t [8];
        t[0] = 24'h0A141E; t[1] = 24'h28323C; t[2] = 24'h09141E; t[3] = 24'h29323C;
        t[4] = 24'h0A131E; t[5] = 24'h0A143D; t[6] = 24'h1E2A33; t[7] = 24'hFF0000;
        for (int i = 0; i < 8; i++) begin
            if (dst_side) pix(1, 24'h123456, t[i]);
            else          pix(1, t[i], 24'h654321);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        check("R1", "reset out_valid", {23'd0, out_valid}, 24'd0);
        check("R1", "reset out_px", out_px, 24'd0);
        check("R1", "reset cfg_err", {23'd0, cfg_err}, 24'd0);
        rst_n = 1;
        pix(0, 0, 0);
        @(negedge clk);
        check("R1", "post-reset out_valid", {23'd0, out_valid}, 24'd0);

        req = "R2"; rnd_px(30);
        req = "R5"; wr(1, 0, 24'h0A141E, 24'h28323C, 3'b111);
        req = "R9"; pix(1, 24'h141E28, 24'h777777);
        req = "R5"; edge_px(0); rnd_px(20);
        req = "R4"; wr(1, 0, 24'h0A141E, 24'h28323C, 3'b010); edge_px(0);
        wr(1, 0, 24'h0A141E, 24'h28323C, 3'b000); rnd_px(10);
        req = "R6"; wr(0, 1, 24'h0A141E, 24'h28323C, 3'b101); edge_px(1);
        wr(0, 1, 24'h0A141E, 24'h28323C, 3'b111); edge_px(1); rnd_px(20);
        req = "R7"; wr(1, 1, 24'h000000, 24'hFFFFFF, 3'b000);
        edge_px(1); edge_px(0);
        req = "R8"; wr(0, 1, 24'h0A141E, 24'h28323C, 3'b111); edge_px(1);
        req = "R9"; wr(1, 0, 24'h0A141E, 24'h28323C, 3'b111); edge_px(0);
        req = "R3"; pix(1, 24'hABCDEF, 24'h0); pix(0, 24'h111111, 24'h0);
        pix(0, 24'h222222, 24'h0); rnd_px(20);
        req = "R2"; wr(0, 0, 24'h0, 24'hFFFFFF, 3'b111); rnd_px(15);
        pix(0, 0, 0); @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule